// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block walks the column address of one SDRAM read or write burst. When a column command is accepted, the block captures the starting column together with the programmed burst length and burst order. It then presents one column address per clock, starting in the cycle after the command. It flags every cycle that carries a beat and marks the final beat of a fixed-length burst.

Fixed bursts of 2, 4 or 8 beats stay inside the aligned block of that size. They use either a wrapping increment or an exclusive-OR order. A full-page burst counts through the whole column space and wraps from the top column to zero. It keeps counting until a stop request arrives. A memory controller or a memory model uses the block as the column counter behind its command decoder. The data path and command decoding belong to the surrounding logic.

Top module: `sdram_burst_colgen`

## Requirements
- R1: While reset is asserted, and asynchronously as soon as it asserts, `beat_valid_o` and `beat_last_o` are 0. Reset is released through a two-stage synchronizer.
- R2: `go_i` high at a rising edge captures `col_start_i`, `len_code_i` and `order_i`. In the following cycle, `beat_valid_o` is 1 and `col_o` equals the captured start column.
- R3: `len_code_i` encodes the burst length as follows: 0 gives 1 beat, 1 gives 2, 2 gives 4, 3 gives 8 and 7 gives full page. The reserved codes 4, 5 and 6 give 1 beat. A fixed burst holds `beat_valid_o` high for exactly that many consecutive cycles.
- R4: With `order_i` = 0 (sequential), beat k of an N-beat burst places ((start mod N) + k) mod N in the low log2(N) column bits. The upper bits keep the start value.
- R5: With `order_i` = 1 (interleaved), beat k of an N-beat burst places (start XOR k) in the low log2(N) column bits. The upper bits keep the start value.
- R6: In full-page mode, beat k gives (start + k) mod 1024, whatever the value of `order_i`. The burst never raises `beat_last_o` and continues until it is stopped.
- R7: `beat_last_o` is 1 only on the final beat of a fixed burst. A 1-beat burst shows a single beat with `beat_last_o` set. After the last beat, `beat_valid_o` falls unless a new burst starts.
- R8: `stop_i` high at a rising edge makes the beat shown in that cycle the final one, so `beat_valid_o` falls in the next cycle. If `go_i` is high at the same edge, the new burst takes effect and the stop is ignored.
- R9: `go_i` during a burst, including on its last beat, starts the new burst in the next cycle with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go_i | input | 1 | Column command accepted; start a burst |
| col_start_i | input | 10 | Starting column of the burst |
| len_code_i | input | 3 | Burst length code (see R3) |
| order_i | input | 1 | 0 sequential, 1 interleaved |
| stop_i | input | 1 | End the running burst after the current beat |
| col_o | output | 10 | Column address of the current beat |
| beat_valid_o | output | 1 | A beat is presented this cycle |
| beat_last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The bench starts sequential bursts near the top of an aligned block and near the top of the column space. An adder that carried into the upper bits would then change the held row of columns, or spill past column 1023. Interleaved bursts with nonzero low start bits show up an order that is mixed up with the sequential one. A full-page burst with `order_i` set to 1 crosses from 1023 to 0 and then stops. This catches a design that applied the exclusive-OR order, failed to wrap, or raised a last flag. Further directed cases cover a 1-beat burst, the reserved length codes, stop in the middle of a fixed burst, a start together with a stop, a start on the last beat, and reset asserted in the middle of a burst. A design that dropped a cycle, added a gap or let the stop win would miscount the beats in these cases.

// File: rtl/colgen_pkg.sv
package colgen_pkg;

  // Burst ordering selected with the column command
  typedef enum logic {
    ORD_SEQ = 1'b0,
    ORD_ILV = 1'b1
  } order_e;

  // Length code values with a defined meaning
  localparam int unsigned LEN_CODE_W   = 3;
  localparam int unsigned MAX_FIX_LOG2 = 3;   // codes 0..3 give 1..8 beats
  localparam int unsigned PAGE_CODE    = 7;   // full-page burst

endpackage

// File: rtl/colgen_rst_sync.sv
module colgen_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/colgen_cfg_decode.sv
module colgen_cfg_decode
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic [LEN_CODE_W-1:0] code_i,
  input  logic                  order_i,
  output logic [COL_W-1:0]      mask_o,
  output logic                  full_o,
  output logic                  ilv_o
);

  logic fixed;

  // Codes 0..MAX_FIX_LOG2 are power-of-two lengths; reserved ones give mask 0
  assign fixed  = (code_i <= LEN_CODE_W'(MAX_FIX_LOG2));
  assign full_o = (code_i == LEN_CODE_W'(PAGE_CODE));
  assign ilv_o  = (order_e'(order_i) == ORD_ILV) && !full_o;

  // Bit b wraps inside the burst when b < log2(length)
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    if (b < MAX_FIX_LOG2) begin : g_low
      assign mask_o[b] = fixed && (code_i > LEN_CODE_W'(b));
    end else begin : g_high
      assign mask_o[b] = 1'b0;
    end
  end

endmodule

// File: rtl/colgen_beat_ctr.sv
module colgen_beat_ctr #(
  parameter int unsigned COL_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  output logic [COL_W-1:0] idx_o,
  output logic             final_o
);

  localparam logic [COL_W-1:0] STEP = COL_W'(1);

  logic [COL_W-1:0] idx_q;
  logic [COL_W-1:0] idx_d;
  logic             idx_en;

  always_comb begin
    idx_en = load_i || adv_i;
    idx_d  = idx_q;
    if (load_i) begin
      idx_d = '0;
    end else if (adv_i) begin
      idx_d = idx_q + STEP;   // wraps modulo 2**COL_W in full-page mode
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign idx_o   = idx_q;
  // The beat index reaches length-1 exactly when it equals the wrap mask
  assign final_o = !full_i && (idx_q == mask_i);

endmodule

// File: rtl/colgen_addr_form.sv
module colgen_addr_form #(
  parameter int unsigned COL_W = 10
) (
  input  logic [COL_W-1:0] base_i,
  input  logic [COL_W-1:0] idx_i,
  input  logic [COL_W-1:0] mask_i,
  input  logic             full_i,
  input  logic             ilv_i,
  output logic [COL_W-1:0] col_o
);

  logic [COL_W-1:0] sum;
  logic [COL_W-1:0] mix;
  logic [COL_W-1:0] low;

  always_comb begin
    sum = base_i + idx_i;
    mix = base_i ^ idx_i;
    low = ilv_i ? mix : sum;
    if (full_i) begin
      col_o = sum;
    end else begin
      col_o = (base_i & ~mask_i) | (low & mask_i);
    end
  end

endmodule

// File: rtl/sdram_burst_colgen.sv
module sdram_burst_colgen
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  go_i,
  input  logic [COL_W-1:0]      col_start_i,
  input  logic [LEN_CODE_W-1:0] len_code_i,
  input  logic                  order_i,
  input  logic                  stop_i,
  output logic [COL_W-1:0]      col_o,
  output logic                  beat_valid_o,
  output logic                  beat_last_o
);

  logic             rst_core_n;

  logic [COL_W-1:0] dec_mask;
  logic             dec_full;
  logic             dec_ilv;

  logic             act_q,  act_d;
  logic [COL_W-1:0] base_q;
  logic [COL_W-1:0] mask_q;
  logic             full_q;
  logic             ilv_q;

  logic [COL_W-1:0] idx;
  logic             at_final;
  logic             adv;

  colgen_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  colgen_cfg_decode #(.COL_W(COL_W)) u_dec (
    .code_i  (len_code_i),
    .order_i (order_i),
    .mask_o  (dec_mask),
    .full_o  (dec_full),
    .ilv_o   (dec_ilv)
  );

  // Next-state for the burst-active flag
  always_comb begin
    adv   = act_q && !go_i && !stop_i && !at_final;
    act_d = act_q;
    if (go_i) begin
      act_d = 1'b1;
    end else if (act_q && (stop_i || at_final)) begin
      act_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_d;
    end
  end

  // Burst settings, loaded only with a command
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      base_q <= '0;
      mask_q <= '0;
      full_q <= 1'b0;
      ilv_q  <= 1'b0;
    end else if (go_i) begin
      base_q <= col_start_i;
      mask_q <= dec_mask;
      full_q <= dec_full;
      ilv_q  <= dec_ilv;
    end
  end

  colgen_beat_ctr #(.COL_W(COL_W)) u_ctr (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .load_i  (go_i),
    .adv_i   (adv),
    .mask_i  (mask_q),
    .full_i  (full_q),
    .idx_o   (idx),
    .final_o (at_final)
  );

  colgen_addr_form #(.COL_W(COL_W)) u_form (
    .base_i (base_q),
    .idx_i  (idx),
    .mask_i (mask_q),
    .full_i (full_q),
    .ilv_i  (ilv_q),
    .col_o  (col_o)
  );

  assign beat_valid_o = act_q;
  assign beat_last_o  = act_q && at_final;

endmodule

// File: rtl/colgen_chk.sv
module colgen_chk
  import colgen_pkg::*;
#(
  parameter int unsigned COL_W = 10
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  go_i,
  input logic [COL_W-1:0]      col_start_i,
  input logic [LEN_CODE_W-1:0] len_code_i,
  input logic                  stop_i,
  input logic [COL_W-1:0]      col_o,
  input logic                  beat_valid_o,
  input logic                  beat_last_o
);

  // R7
  last_in_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last_o |-> beat_valid_o);

  // R2
  first_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_i |=> (beat_valid_o && col_o == $past(col_start_i)));

  // R8
  stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && !go_i) |=> !beat_valid_o);

  // R7
  last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last_o && !go_i) |=> !beat_valid_o);

  // R3
  keeps_going_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_valid_o && !beat_last_o && !stop_i && !go_i) |=> beat_valid_o);

  // R6
  page_no_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_i && len_code_i == LEN_CODE_W'(PAGE_CODE)) |=> !beat_last_o);

endmodule

bind sdram_burst_colgen colgen_chk #(.COL_W(COL_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_core_n),
  .go_i         (go_i),
  .col_start_i  (col_start_i),
  .len_code_i   (len_code_i),
  .stop_i       (stop_i),
  .col_o        (col_o),
  .beat_valid_o (beat_valid_o),
  .beat_last_o  (beat_last_o)
);

// File: tb/sdram_burst_colgen_tb.sv
module sdram_burst_colgen_tb;

  logic       clk;
  logic       rst_n;
  logic       go_i;
  logic [9:0] col_start_i;
  logic [2:0] len_code_i;
  logic       order_i;
  logic       stop_i;
  logic [9:0] col_o;
  logic       beat_valid_o;
  logic       beat_last_o;

  int n_chk;
  int n_bad;
  bit done;

  sdram_burst_colgen u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .go_i         (go_i),
    .col_start_i  (col_start_i),
    .len_code_i   (len_code_i),
    .order_i      (order_i),
    .stop_i       (stop_i),
    .col_o        (col_o),
    .beat_valid_o (beat_valid_o),
    .beat_last_o  (beat_last_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // {start column, length code, order}
  localparam logic [13:0] VEC [8] = '{
    {10'h005, 3'd1, 1'b0},
    {10'h00E, 3'd2, 1'b0},
    {10'h3FD, 3'd3, 1'b0},
    {10'h0B6, 3'd3, 1'b1},
    {10'h123, 3'd2, 1'b1},
    {10'h201, 3'd0, 1'b0},
    {10'h2AA, 3'd0, 1'b1},
    {10'h077, 3'd5, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int beats_of(input int code);
    case (code)
      1: return 2;
      2: return 4;
      3: return 8;
      default: return 1;
    endcase
  endfunction

  function automatic int want_col(input int s, input int n, input bit ilv, input int k);
    int hi, lo;
    hi = s - (s % n);
    lo = s % n;
    if (ilv) return hi + ((lo ^ k) % n);
    return hi + ((lo + k) % n);
  endfunction

  task automatic issue(input int s, input int code, input bit ord);
    go_i        = 1'b1;
    col_start_i = 10'(s);
    len_code_i  = 3'(code);
    order_i     = ord;
    @(negedge clk);
    go_i = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    finish_run();
  end

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0;
    rst_n = 1'b0; go_i = 1'b0; col_start_i = '0; len_code_i = '0;
    order_i = 1'b0; stop_i = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(beat_valid_o == 1'b0, "R1 valid in reset", beat_valid_o, 0);
    chk(beat_last_o == 1'b0, "R1 last in reset", beat_last_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(beat_valid_o == 1'b0, "R1 idle after reset", beat_valid_o, 0);

    // Table walk: R2 R3 R4 R5 R7
    for (int v = 0; v < 8; v++) begin
      int s, code, n;
      bit ord;
      s = int'(VEC[v][13:4]); code = int'(VEC[v][3:1]); ord = VEC[v][0];
      n = beats_of(code);
      issue(s, code, ord);
      for (int k = 0; k < n; k++) begin
        int e;
        e = want_col(s, n, ord, k);
        chk(beat_valid_o == 1'b1, "R3 valid during burst", beat_valid_o, 1);
        chk(int'(col_o) == e, ord ? "R5 interleaved column" : "R4 sequential column",
            int'(col_o), e);
        chk(beat_last_o == (k == n - 1), "R7 last flag", beat_last_o, int'(k == n - 1));
        @(negedge clk);
      end
      chk(beat_valid_o == 1'b0, "R3 burst length", beat_valid_o, 0);
    end

    // R6 full page, interleave requested, wraps 1023 -> 0, stopped by R8
    issue(1020, 7, 1'b1);
    for (int k = 0; k < 10; k++) begin
      int e;
      e = (1020 + k) % 1024;
      chk(beat_valid_o == 1'b1, "R6 page valid", beat_valid_o, 1);
      chk(int'(col_o) == e, "R6 page column", int'(col_o), e);
      chk(beat_last_o == 1'b0, "R6 page no last", beat_last_o, 0);
      if (k == 9) stop_i = 1'b1;
      @(negedge clk);
    end
    stop_i = 1'b0;
    chk(beat_valid_o == 1'b0, "R8 stop on page", beat_valid_o, 1'b0);

    // R8 stop in the middle of an 8-beat burst
    issue(10'h040, 3, 1'b0);
    @(negedge clk);
    stop_i = 1'b1;
    chk(int'(col_o) == 10'h041, "R8 beat before stop", int'(col_o), 10'h041);
    @(negedge clk);
    stop_i = 1'b0;
    chk(beat_valid_o == 1'b0, "R8 stop mid burst", beat_valid_o, 0);

    // R9 start on the last beat: no gap
    issue(10'h010, 1, 1'b0);
    @(negedge clk);
    chk(beat_last_o == 1'b1, "R7 last of 2-beat", beat_last_o, 1);
    issue(10'h105, 2, 1'b1);
    for (int k = 0; k < 4; k++) begin
      int e;
      e = want_col(10'h105, 4, 1'b1, k);
      chk(beat_valid_o == 1'b1, "R9 back-to-back valid", beat_valid_o, 1);
      chk(int'(col_o) == e, "R9 back-to-back column", int'(col_o), e);
      @(negedge clk);
    end
    chk(beat_valid_o == 1'b0, "R9 second burst ends", beat_valid_o, 0);

    // R8 start together with stop: start wins; also restart mid burst (R9)
    issue(10'h080, 3, 1'b0);
    @(negedge clk);
    stop_i = 1'b1;
    issue(10'h300, 0, 1'b0);
    stop_i = 1'b0;
    chk(beat_valid_o == 1'b1, "R8 start beats stop", beat_valid_o, 1);
    chk(int'(col_o) == 10'h300, "R9 restart column", int'(col_o), 10'h300);
    chk(beat_last_o == 1'b1, "R7 single beat last", beat_last_o, 1);
    @(negedge clk);
    chk(beat_valid_o == 1'b0, "R7 single beat ends", beat_valid_o, 0);

    // R1 asynchronous reset in the middle of a burst
    issue(10'h1F0, 3, 1'b1);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(beat_valid_o == 1'b0, "R1 async reset valid", beat_valid_o, 0);
    chk(beat_last_o == 1'b0, "R1 async reset last", beat_last_o, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(beat_valid_o == 1'b0, "R1 idle after second reset", beat_valid_o, 0);

    finish_run();
  end

endmodule